// File: doc/BRIEF.md
# Two-Phase Channel Sender Controller

This block sits at the producer edge of a clocked domain and pushes data words onto a bundled-data channel that leads into a self-timed buffer. A word is announced by flipping the request line once; the word itself is held in an output register that only loads when a new word is sent, so the data stays still around every request change. Producer logic hands words in over a valid/ready pair.

Two pacing schemes are available, chosen by a mode input. In acknowledge pacing, the controller waits after each request flip until the synchronised two-phase acknowledge comes back level-equal to the request. That round trip caps the rate at one word every second clock. In fast pacing, the acknowledge is ignored. The controller sends whenever the downstream buffer reports its first stage empty, which allows one word per clock when the buffer has at least two entries. In both schemes a stalled downstream leaves the last word parked in the output register with no further request flip.

Top module: `tpc_sender`

## Requirements
- R1: While reset is asserted and after it is released, req_o is 0 and out_data_o is 0. With ack_i low in acknowledge pacing, or consumed_i high in fast pacing, in_ready_o is high.
- R2: A word is accepted on a rising clock edge where in_valid_i and in_ready_o are both high. out_load_o is high in exactly those cycles, and after that edge out_data_o holds the accepted word and req_o has flipped exactly once.
- R3: On an edge with no acceptance, out_data_o and req_o keep their values.
- R4: In acknowledge pacing (mode_fast_i = 0), in_ready_o is high exactly when ack_i equals req_o, so no second request flip occurs before the matching acknowledge.
- R5: In acknowledge pacing with an acknowledge that returns one cycle after capture and an unstalled consumer, a continuously valid producer gets one word accepted every two clocks.
- R6: In fast pacing (mode_fast_i = 1), in_ready_o equals consumed_i and ack_i has no effect.
- R7: In fast pacing with an unstalled consumer and a two-entry buffer, a continuously valid producer gets one word accepted every clock.
- R8: When the downstream buffer is full, in_ready_o stays low and the pending word stays in out_data_o until the buffer takes it.
- R9: Every accepted word reaches the downstream consumer exactly once and in acceptance order, whatever the stall and valid patterns.
- R10: Mode encoding: mode_fast_i = 0 selects acknowledge pacing and mode_fast_i = 1 selects fast pacing. The mode may change between transfers while the channel is settled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_fast_i | input | 1 | 0 = acknowledge pacing, 1 = fast pacing |
| in_valid_i | input | 1 | Producer has a word |
| in_ready_o | output | 1 | Controller can take a word this cycle |
| in_data_i | input | DATA_W | Producer word |
| out_data_o | output | DATA_W | Bundled channel data (held register) |
| out_load_o | output | 1 | Load enable of the output register |
| req_o | output | 1 | Two-phase request level |
| ack_i | input | 1 | Synchronised two-phase acknowledge level |
| consumed_i | input | 1 | Downstream first stage empty |

## Verification
The bench sweeps both pacing modes against consumer stall densities and producer valid patterns, using a two-entry queue model with a delayed acknowledge. It targets the full-buffer hold. A design that loaded the register or flipped the request there would overwrite an undelivered word or send a duplicate, and the in-order delivery check would report it. With the consumer never stalled, the count of accepted words is compared with half the cycles in acknowledge pacing and with all the cycles in fast pacing. A controller that ignored the acknowledge, or that waited for one in fast mode, lands on the wrong count. In fast mode the acknowledge line is driven to disagree with the request, so a controller that still looked at it would drop ready.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic {
    PACE_ACK  = 1'b0,
    PACE_FAST = 1'b1
  } pace_mode_e;
endpackage

// File: rtl/tpc_phase_track.sv
module tpc_phase_track (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic ack_i,
  output logic req_o,
  output logic settled_o
);
  logic req_q;
  logic req_d;

  always_comb begin
    req_d = req_q;
    if (step_i) req_d = ~req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req_o     = req_q;
  assign settled_o = (ack_i == req_q);

  // R2: a send step flips the request once
  a_r2_flip_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (req_q != $past(req_q)));
  // R3: request is steady without a step
  a_r3_req_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(req_q));
endmodule

// File: rtl/tpc_pace_sel.sv
module tpc_pace_sel
  import tpc_pkg::*;
(
  input  pace_mode_e mode_i,
  input  logic       settled_i,
  input  logic       consumed_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       load_o
);
  always_comb begin
    unique case (mode_i)
      PACE_FAST: ready_o = consumed_i;
      default:   ready_o = settled_i;
    endcase
    load_o = valid_i & ready_o;
  end
endmodule

// File: rtl/tpc_hold_reg.sv
module tpc_hold_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q_q;
    if (en_i) q_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R3: held word does not move without a load
  a_r3_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(q_q));
  // R2: a load captures the presented word
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (q_q == $past(d_i)));
endmodule

// File: rtl/tpc_sender.sv
module tpc_sender
  import tpc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_fast_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_load_o,
  output logic              req_o,
  input  logic              ack_i,
  input  logic              consumed_i
);
  pace_mode_e mode;
  logic       settled;
  logic       load;

  assign mode = pace_mode_e'(mode_fast_i);

  tpc_phase_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (load),
    .ack_i     (ack_i),
    .req_o     (req_o),
    .settled_o (settled)
  );

  tpc_pace_sel u_pace (
    .mode_i     (mode),
    .settled_i  (settled),
    .consumed_i (consumed_i),
    .valid_i    (in_valid_i),
    .ready_o    (in_ready_o),
    .load_o     (load)
  );

  tpc_hold_reg #(.WIDTH(DATA_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (load),
    .d_i   (in_data_i),
    .q_o   (out_data_o)
  );

  assign out_load_o = load;

  // R4: no second request while an acknowledge is outstanding
  a_r4_wait_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_fast_i && (req_o != ack_i)) |-> !out_load_o);
  // R6 / R8: fast pacing blocks when the first stage is occupied
  a_r6_fast_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fast_i && !consumed_i) |-> !in_ready_o);
  // R2: load only for a valid word
  a_r2_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_load_o |-> in_valid_i);
endmodule

// File: tb/tpc_sender_tb_top.sv
`timescale 1ns/1ps
module tpc_sender_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_fast;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] in_data;
  logic [W-1:0] out_data;
  logic         out_load;
  logic         req;
  logic         ack;
  logic         consumed;

  always #10 clk = ~clk;

  tpc_sender #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_fast_i(mode_fast),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_data_o(out_data), .out_load_o(out_load), .req_o(req),
    .ack_i(ack), .consumed_i(consumed)
  );

  int checks = 0;
  int errors = 0;

  // downstream model state
  logic [W-1:0] q0, q1;
  int           qcnt;
  logic         req_seen, ack_pend, ack_line;
  logic [W-1:0] exp_pop;
  logic [W-1:0] next_word;
  logic [W-1:0] acc_word, data_prev;
  logic         acc_prev, req_prev;
  int           acc_count, pop_count;

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req_tag, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit stall, input bit vld);
    @(negedge clk);
    // R2 / R3: effect of the previous edge
    if (acc_prev) begin
      chk(req != req_prev, "R2 req flip", req, !req_prev);
      chk(out_data == acc_word, "R2 data load", out_data, acc_word);
    end else begin
      chk(req == req_prev, "R3 req hold", req, req_prev);
      chk(out_data == data_prev, "R3 data hold", out_data, data_prev);
    end
    // consumer pop, R9 order
    if (!stall && qcnt > 0) begin
      chk(q0 == exp_pop, "R9 in-order delivery", q0, exp_pop);
      exp_pop++;
      pop_count++;
      q0 = q1;
      qcnt--;
    end
    // capture into the two-entry buffer
    ack_line = ack_pend;
    if (req != req_seen) begin
      if (qcnt < 2) begin
        if (qcnt == 0) q0 = out_data; else q1 = out_data;
        qcnt++;
        req_seen = req;
      end
    end
    ack_pend = req_seen;
    chk(qcnt <= 2, "R9 no overflow", qcnt, 2);
    // drive inputs
    ack      = mode_fast ? ~req : ack_line;
    consumed = (qcnt < 2);
    in_valid = vld;
    in_data  = next_word;
    #1;
    if (mode_fast)
      chk(in_ready == consumed, "R6 ready follows consumed", in_ready, consumed);
    else
      chk(in_ready == (ack == req), "R4 ready waits ack", in_ready, ack == req);
    if (qcnt == 2 && req != req_seen)
      chk(!in_ready, "R8 hold when full", in_ready, 0);
    chk(out_load == (vld && in_ready), "R2 load enable", out_load, vld && in_ready);
    acc_prev  = vld && in_ready;
    req_prev  = req;
    data_prev = out_data;
    if (acc_prev) begin
      acc_word = next_word;
      next_word++;
      acc_count++;
    end
  endtask

  initial begin
    #(200_000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_fast = 1'b0; in_valid = 1'b0; in_data = '0;
    ack = 1'b0; consumed = 1'b1;
    qcnt = 0; q0 = '0; q1 = '0; req_seen = 1'b0; ack_pend = 1'b0; ack_line = 1'b0;
    exp_pop = '0; next_word = '0; acc_word = '0; acc_prev = 1'b0;
    acc_count = 0; pop_count = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(req == 1'b0, "R1 reset req", req, 0);
    chk(out_data == '0, "R1 reset data", out_data, 0);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1 ready after release", in_ready, 1);
    req_prev = 1'b0; data_prev = '0;

    for (int m = 0; m < 2; m++) begin
      for (int sk = 0; sk < 4; sk++) begin
        for (int vp = 0; vp < 3; vp++) begin
          int base;
          @(negedge clk);
          mode_fast = m[0];  // R10 mode encoding
          #1;
          req_prev = req; data_prev = out_data;
          base = acc_count;
          for (int c = 0; c < 60; c++) begin
            bit st, v;
            st = ((c % 4) < sk);
            v  = (vp == 0) ? 1'b1 : ((c % (vp + 1)) == 0);
            cycle(st, v);
          end
          if (sk == 0 && vp == 0) begin
            if (m == 0)
              chk((acc_count - base) >= 29 && (acc_count - base) <= 31,
                  "R5 ack throughput", acc_count - base, 30);
            else
              chk((acc_count - base) >= 59,
                  "R7 fast throughput", acc_count - base, 60);
          end
          for (int c = 0; c < 10; c++) cycle(1'b0, 1'b0);
          chk(pop_count == acc_count, "R9 exactly once", pop_count, acc_count);
          chk(ack_line == req, "R10 settled before mode change", ack_line, req);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule